// File: doc/BRIEF.md
# Masked Word AND Operator

This block forms the bitwise AND of two secret words without ever putting either secret, or the secret result, on a wire. Each operand arrives split into two shares: a masked value and the random mask that hides it. The unmasked operand is the XOR of the two, but the block never forms that XOR. A third random word, the output mask, comes in with the operands. The block returns a masked result that, XORed with the output mask, gives the AND of the hidden operands.

Each bit position is computed on its own and all bits are computed in the same cycle. The result is built from the four cross products of the shares. The output mask enters the XOR chain first, so no partial sum is correlated with the plain value. A transfer is accepted when `in_valid` is high. The masked result and the output mask it was made with are registered and appear one clock later with `out_valid`. A gated test port gives the recombined result for production test. Random masks come from outside the block.

Top module: `masked_and_word`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `qm` and `mq_out` are cleared to zero at that edge.
- R2: `out_valid` is high in the cycle after an edge at which `in_valid` was high outside reset, and low after an edge at which `in_valid` was low.
- R3: After a transfer, `qm XOR mq_out` equals `(am XOR ma) AND (bm XOR mb)` of the captured inputs, on all WIDTH bits.
- R4: `mq_out` equals the output mask `mq` captured in the same transfer.
- R5: While `in_valid` is low, `qm` and `mq_out` keep their values, whatever is on the data inputs.
- R6: Bit i of the result depends only on bit i of the five input words. A single set bit in one operand with the other operand all ones gives a recombined result with only that bit set.
- R7: `tst_plain` equals `qm XOR mq_out` while `tst_en` is high and is all zeros while `tst_en` is low.
- R8: With both input masks zero, `qm` equals `(am AND bm) XOR mq`. With the output mask zero, `qm` equals the plain AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input words are captured at this edge |
| am | input | WIDTH | First operand, masked share |
| ma | input | WIDTH | Mask of the first operand |
| bm | input | WIDTH | Second operand, masked share |
| mb | input | WIDTH | Mask of the second operand |
| mq | input | WIDTH | Fresh output mask |
| out_valid | output | 1 | Registered result is new this cycle |
| qm | output | WIDTH | Masked AND result |
| mq_out | output | WIDTH | Output mask that goes with `qm` |
| tst_en | input | 1 | Opens the test unmask port |
| tst_plain | output | WIDTH | Recombined result for test, zero when closed |

## Verification
A wrong cross product or a wrong chain term flips some bit of `qm XOR mq_out` one cycle after the transfer. Because the masks are random, the error shows on random bits, so a long run of random transfers catches it within a few vectors. If the output mask register is not kept in step with the result register, `mq_out` and the unmasked result both go wrong in the cycle after a transfer. If the hold logic is wrong, the outputs change during cycles with no transfer. Walking a single bit through one operand shows at once if one bit position leaks into another.

// File: rtl/mand_pkg.sv
package mand_pkg;

   // Widest word the library accepts. It keeps the elaborated gate count small.
   localparam int unsigned MAND_MAX_WIDTH = 1024;

   // Shares of one masked bit
   typedef struct packed {
      logic val;   // masked value
      logic msk;   // its mask
   } mand_share_t;

endpackage

// File: rtl/mand_bit.sv
// Masked AND for one bit. The output mask enters the chain before any
// cross product, so every partial sum stays masked.
module mand_bit
   import mand_pkg::*;
(
   input  mand_share_t op_a,
   input  mand_share_t op_b,
   input  logic        fresh,
   output logic        q_masked
);
   logic p_mask_mask;
   logic p_mb_am;
   logic p_bm_ma;
   logic p_val_val;
   logic acc_0;
   logic acc_1;
   logic acc_2;

   assign p_mask_mask = op_a.msk & op_b.msk;
   assign p_mb_am     = op_b.msk & op_a.val;
   assign p_bm_ma     = op_b.val & op_a.msk;
   assign p_val_val   = op_a.val & op_b.val;

   assign acc_0    = fresh ^ p_mask_mask;
   assign acc_1    = acc_0 ^ p_mb_am;
   assign acc_2    = acc_1 ^ p_bm_ma;
   assign q_masked = acc_2 ^ p_val_val;
endmodule

// File: rtl/mand_word.sv
// Replicates the masked AND bit slice across the word.
module mand_word
   import mand_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] am,
   input  logic [WIDTH-1:0] ma,
   input  logic [WIDTH-1:0] bm,
   input  logic [WIDTH-1:0] mb,
   input  logic [WIDTH-1:0] mq,
   output logic [WIDTH-1:0] q_comb
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      mand_share_t sa;
      mand_share_t sb;
      assign sa.val = am[i];
      assign sa.msk = ma[i];
      assign sb.val = bm[i];
      assign sb.msk = mb[i];
      mand_bit u_bit (
         .op_a     (sa),
         .op_b     (sb),
         .fresh    (mq[i]),
         .q_masked (q_comb[i])
      );
   end
endmodule

// File: rtl/mand_out_reg.sv
// Output stage: the masked result and its mask are captured together.
module mand_out_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] q_in,
   input  logic [WIDTH-1:0] m_in,
   output logic             vld_q,
   output logic [WIDTH-1:0] q_q,
   output logic [WIDTH-1:0] m_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         q_q   <= '0;
         m_q   <= '0;
      end else begin
         vld_q <= load;
         if (load) begin
            q_q <= q_in;
            m_q <= m_in;
         end
      end
   end
endmodule

// File: rtl/mand_unmask.sv
// Test-only recombination. It is gated by an enable, and a parameter can remove it.
module mand_unmask #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          PRESENT = 1'b1
) (
   input  logic             en,
   input  logic [WIDTH-1:0] q_masked,
   input  logic [WIDTH-1:0] q_mask,
   output logic [WIDTH-1:0] plain
);
   if (PRESENT) begin : g_open
      assign plain = en ? (q_masked ^ q_mask) : '0;
   end else begin : g_tied
      logic unused_ok;
      assign unused_ok = ^{en, q_masked, q_mask};
      assign plain     = '0;
   end
endmodule

// File: rtl/masked_and_word.sv
module masked_and_word
   import mand_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter bit          TST_PORT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] am,
   input  logic [WIDTH-1:0] ma,
   input  logic [WIDTH-1:0] bm,
   input  logic [WIDTH-1:0] mb,
   input  logic [WIDTH-1:0] mq,
   output logic             out_valid,
   output logic [WIDTH-1:0] qm,
   output logic [WIDTH-1:0] mq_out,
   input  logic             tst_en,
   output logic [WIDTH-1:0] tst_plain
);
   if (WIDTH < 1 || WIDTH > MAND_MAX_WIDTH) begin : g_bad_width
      $error("masked_and_word: WIDTH out of range");
   end

   logic [WIDTH-1:0] q_comb;

   mand_word #(.WIDTH(WIDTH)) u_word (
      .am     (am),
      .ma     (ma),
      .bm     (bm),
      .mb     (mb),
      .mq     (mq),
      .q_comb (q_comb)
   );

   mand_out_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .load  (in_valid),
      .q_in  (q_comb),
      .m_in  (mq),
      .vld_q (out_valid),
      .q_q   (qm),
      .m_q   (mq_out)
   );

   mand_unmask #(.WIDTH(WIDTH), .PRESENT(TST_PORT_EN)) u_tst (
      .en       (tst_en),
      .q_masked (qm),
      .q_mask   (mq_out),
      .plain    (tst_plain)
   );
endmodule

// File: rtl/mand_chk.sv
module mand_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter bit          TST_PORT_EN = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [WIDTH-1:0] am,
   input logic [WIDTH-1:0] ma,
   input logic [WIDTH-1:0] bm,
   input logic [WIDTH-1:0] mb,
   input logic [WIDTH-1:0] mq,
   input logic             out_valid,
   input logic [WIDTH-1:0] qm,
   input logic [WIDTH-1:0] mq_out,
   input logic             tst_en,
   input logic [WIDTH-1:0] tst_plain
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (rst) armed <= 1'b1;

   AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!armed)
      $past(rst) |-> (!out_valid && qm == '0 && mq_out == '0)); // R1
   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst || !armed)
      in_valid |=> out_valid); // R2
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst || !armed)
      !in_valid |=> !out_valid); // R2
   AST_UNMASK_OK: assert property (@(posedge clk) disable iff (rst || !armed)
      in_valid |=> ((qm ^ mq_out) == ($past(am ^ ma) & $past(bm ^ mb)))); // R3
   AST_MASK_CARRY: assert property (@(posedge clk) disable iff (rst || !armed)
      in_valid |=> (mq_out == $past(mq))); // R4
   AST_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
      !in_valid |=> ($stable(qm) && $stable(mq_out))); // R5
   AST_TST_GATE: assert property (@(posedge clk) disable iff (rst || !armed)
      !tst_en |-> (tst_plain == '0)); // R7
   if (TST_PORT_EN) begin : g_tst_open
      AST_TST_OPEN: assert property (@(posedge clk) disable iff (rst || !armed)
         tst_en |-> (tst_plain == (qm ^ mq_out))); // R7
   end
endmodule

bind masked_and_word mand_chk #(.WIDTH(WIDTH), .TST_PORT_EN(TST_PORT_EN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .am        (am),
   .ma        (ma),
   .bm        (bm),
   .mb        (mb),
   .mq        (mq),
   .out_valid (out_valid),
   .qm        (qm),
   .mq_out    (mq_out),
   .tst_en    (tst_en),
   .tst_plain (tst_plain)
);

// File: tb/sim_masked_and_word.sv
`timescale 1ns/1ps
module sim_masked_and_word;
   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] am = '0, ma = '0, bm = '0, mb = '0, mq = '0;
   logic         out_valid;
   logic [W-1:0] qm, mq_out, tst_plain;
   logic         tst_en = 1'b1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   masked_and_word #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .am(am), .ma(ma), .bm(bm), .mb(mb), .mq(mq),
      .out_valid(out_valid), .qm(qm), .mq_out(mq_out),
      .tst_en(tst_en), .tst_plain(tst_plain)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drives one transfer from plain operands and masks, then checks one cycle later.
   task automatic transfer(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] xa, input logic [W-1:0] xb, input logic [W-1:0] xq);
      @(negedge clk);
      am = a ^ xa; ma = xa; bm = b ^ xb; mb = xb; mq = xq; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " R2 out_valid"}, W'(out_valid), W'(1));
      check({req, " R3 unmasked"}, qm ^ mq_out, a & b);
      check({req, " R4 mask"}, mq_out, xq);
      check({req, " R8 qm"}, qm, (a & b) ^ xq);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R1 out_valid", W'(out_valid), '0);
      check("R1 qm", qm, '0);
      check("R1 mq_out", mq_out, '0);
      rst = 1'b0;
   endtask

   task automatic t_random();
      for (int n = 0; n < 300; n++) begin
         transfer("rand", W'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom));
         check("R7 open", tst_plain, qm ^ mq_out);
      end
   endtask

   task automatic t_corners();
      transfer("R8 zero in-masks", 8'hA5, 8'h3C, 8'h00, 8'h00, 8'h96);
      transfer("R8 zero out-mask", 8'hF0, 8'h5A, 8'h77, 8'h19, 8'h00);
      transfer("R8 all-ones masks", 8'hC3, 8'h81, 8'hFF, 8'hFF, 8'hFF);
      transfer("R3 all ones", 8'hFF, 8'hFF, 8'h2D, 8'hB4, 8'h6E);
      transfer("R3 all zero", 8'h00, 8'h00, 8'hE1, 8'h1E, 8'h55);
   endtask

   task automatic t_bitwalk();
      for (int i = 0; i < W; i++) begin
         transfer("R6 walk", W'(1) << i, '1, W'($urandom), W'($urandom), W'($urandom));
         check("R6 one-hot", qm ^ mq_out, W'(1) << i);
      end
   endtask

   task automatic t_hold();
      logic [W-1:0] q_keep, m_keep;
      transfer("R5 setup", 8'h6B, 8'hD9, 8'h13, 8'h8E, 8'h4F);
      q_keep = qm; m_keep = mq_out;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         am = W'($urandom); bm = W'($urandom); ma = W'($urandom); mb = W'($urandom); mq = W'($urandom);
      end
      @(negedge clk);
      check("R2 out_valid low", W'(out_valid), '0);
      check("R5 qm held", qm, q_keep);
      check("R5 mq_out held", mq_out, m_keep);
   endtask

   task automatic t_tst_gate();
      transfer("R7 setup", 8'hFF, 8'hF7, 8'h5A, 8'hA5, 8'h3C);
      tst_en = 1'b0;
      #1;
      check("R7 closed", tst_plain, '0);
      tst_en = 1'b1;
      #1;
      check("R7 reopen", tst_plain, 8'hF7);
   endtask

   task automatic t_reset_mid();
      transfer("R1 setup", 8'hEE, 8'h7F, 8'h01, 8'h80, 8'hAA);
      t_reset();
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_random();
      t_corners();
      t_bitwalk();
      t_hold();
      t_tst_gate();
      t_reset_mid();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule